// File: doc/BRIEF.md
# Circular-Buffer Data Address Generator

This block turns a small bank of 16-bit pointers into 24-bit data addresses. Each request names one of four index registers. It also names either one of four modify registers or an 8-bit signed immediate. Post-modify emits the current pointer and then advances it. Pre-modify emits the advanced pointer and may write it back or leave the pointer as it was. Each index has a base and a length register. A nonzero length confines the advanced pointer to the window [base, base+length-1] by wrapping it. A length of zero gives plain 16-bit linear stepping.

An 8-bit page register is placed above the 16-bit offset to form the address, so wrapping never carries into the page bits. All index, modify, length, base and page registers exist twice. One select input chooses which copy both the request and the register write port use. A context switch therefore takes a single cycle. Registers are loaded through a simple write port. The address is registered and appears one clock after the request, together with a valid strobe.

Top module: `circ_dag`

## Requirements
- R1: After synchronous reset, addr_valid is 0, addr is 0, and every register of both copies reads as 0.
- R2: A post-modify request (req_pre=0) gives addr = {page, index}. With req_update=1 the index then becomes the modified value.
- R3: A pre-modify request with req_update=1 gives addr = {page, modified index}, and the index keeps that modified value.
- R4: A request with req_update=0 leaves the index register unchanged in either mode. Pre-modify still outputs the modified value.
- R5: When req_imm_en=1, req_imm is taken as an 8-bit two's complement modify value in place of the selected modify register.
- R6: addr[23:16] is the page register of the selected copy, and addr[15:0] is the offset.
- R7: With length 0 the modified index is (index + modify) mod 2^16, and a carry or borrow never changes the page bits.
- R8: With length L>0 and base B, a sum above B+L-1 is reduced by L and a sum below B is raised by L. This applies only while |modify| < L.
- R9: bank_sel=0 selects the primary copy and bank_sel=1 selects the secondary copy, for both writes and requests. The copies are independent.
- R10: A write takes effect at the next clock. If a request updates the same index register in the same cycle, the request's value wins. A write to any other register in that cycle still takes effect.
- R11: addr and addr_valid are registered. addr_valid is 1 exactly in the cycle after a cycle with req_valid=1.
- R12: wr_kind encodes 0 index, 1 modify, 2 length, 3 base, 4 page (the page uses wr_data[7:0]). Codes 5 to 7 change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bank_sel | input | 1 | 0 primary copy, 1 secondary copy |
| wr_en | input | 1 | Register write strobe |
| wr_kind | input | 3 | Register class of the write |
| wr_sel | input | 2 | Register number within the class |
| wr_data | input | 16 | Write value |
| req_valid | input | 1 | Address request strobe |
| req_idx | input | 2 | Index register used by the request |
| req_mod | input | 2 | Modify register used by the request |
| req_imm_en | input | 1 | Use the immediate instead of a modify register |
| req_imm | input | 8 | Signed immediate modify value |
| req_pre | input | 1 | 1 pre-modify, 0 post-modify |
| req_update | input | 1 | Write the modified value back to the index |
| addr | output | 24 | Registered data address |
| addr_valid | output | 1 | addr holds a request's result |

## Verification
On every cycle the assertions check several relations. The valid strobe follows the request by one cycle. The page field matches the selected copy's page register. A pointer that starts inside its circular window stays inside it. An index with no write and no update holds its value, and an update overrides a same-cycle write. Only the bench's scenarios can show that the offsets are numerically correct. The scenarios cover post and pre modes, the no-update pre mode, signed immediates, linear wrap at the 16-bit edge, circular wrap in both directions, independence of the two copies and the ignored write codes.

// File: rtl/dag_pkg.sv
package dag_pkg;
    localparam int OFF_W   = 16;
    localparam int PAGE_W  = 8;
    localparam int IMM_W   = 8;
    localparam int N_PTR   = 4;
    localparam int N_BANK  = 2;
    localparam int SEL_W   = $clog2(N_PTR);
    localparam int ADDR_W  = OFF_W + PAGE_W;

    typedef enum logic [2:0] {
        WK_INDEX  = 3'd0,
        WK_MODIFY = 3'd1,
        WK_LENGTH = 3'd2,
        WK_BASE   = 3'd3,
        WK_PAGE   = 3'd4
    } wr_kind_t;

    typedef struct packed {
        logic [SEL_W-1:0] idx;
        logic [SEL_W-1:0] mod;
        logic             imm_en;
        logic [IMM_W-1:0] imm;
        logic             pre;
        logic             update;
    } dag_req_t;

    function automatic logic [OFF_W-1:0] widen_imm(input logic [IMM_W-1:0] v);
        return {{(OFF_W-IMM_W){v[IMM_W-1]}}, v};
    endfunction
endpackage

// File: rtl/dag_regfile.sv
module dag_regfile
    import dag_pkg::*;
#(
    parameter int W    = OFF_W,
    parameter int PW   = PAGE_W,
    parameter int NP   = N_PTR,
    parameter int NB   = N_BANK,
    localparam int SW  = $clog2(NP),
    localparam int BW  = (NB > 1) ? $clog2(NB) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [BW-1:0] bank,
    input  logic          wr_en,
    input  logic [2:0]    wr_kind,
    input  logic [SW-1:0] wr_sel,
    input  logic [W-1:0]  wr_data,
    input  logic          upd_en,
    input  logic [SW-1:0] upd_sel,
    input  logic [W-1:0]  upd_val,
    input  logic [SW-1:0] rd_isel,
    input  logic [SW-1:0] rd_msel,
    output logic [W-1:0]  rd_idx,
    output logic [W-1:0]  rd_mod,
    output logic [W-1:0]  rd_len,
    output logic [W-1:0]  rd_base,
    output logic [PW-1:0] rd_page
);
    logic [NB-1:0][NP-1:0][W-1:0] idx_q, mod_q, len_q, base_q;
    logic [NB-1:0][PW-1:0]        page_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q  <= '0;
            mod_q  <= '0;
            len_q  <= '0;
            base_q <= '0;
            page_q <= '0;
        end else begin
            for (int b = 0; b < NB; b++) begin
                if (wr_en && (bank == BW'(b))) begin
                    case (wr_kind)
                        WK_INDEX:  idx_q[b][wr_sel]  <= wr_data;
                        WK_MODIFY: mod_q[b][wr_sel]  <= wr_data;
                        WK_LENGTH: len_q[b][wr_sel]  <= wr_data;
                        WK_BASE:   base_q[b][wr_sel] <= wr_data;
                        WK_PAGE:   page_q[b]         <= wr_data[PW-1:0];
                        default: ;
                    endcase
                end
                // pointer update from a request overrides a same-cycle write
                if (upd_en && (bank == BW'(b)))
                    idx_q[b][upd_sel] <= upd_val;
            end
        end
    end

    assign rd_idx  = idx_q[bank][rd_isel];
    assign rd_mod  = mod_q[bank][rd_msel];
    assign rd_len  = len_q[bank][rd_isel];
    assign rd_base = base_q[bank][rd_isel];
    assign rd_page = page_q[bank];

    for (genvar b = 0; b < NB; b++) begin : g_bank_chk
        for (genvar i = 0; i < NP; i++) begin : g_ptr_chk
            // R4: untouched pointer holds its value
            p_idx_hold_r4: assert property (@(posedge clk) disable iff (rst)
                !(wr_en && wr_kind == WK_INDEX && wr_sel == SW'(i) && bank == BW'(b)) &&
                !(upd_en && upd_sel == SW'(i) && bank == BW'(b))
                |=> $stable(idx_q[b][i]));
            // R10: request update wins over a write
            p_upd_wins_r10: assert property (@(posedge clk) disable iff (rst)
                upd_en && upd_sel == SW'(i) && bank == BW'(b)
                |=> idx_q[b][i] == $past(upd_val));
        end
    end
endmodule

// File: rtl/dag_alu.sv
module dag_alu
    import dag_pkg::*;
#(
    parameter int W  = OFF_W,
    parameter int IW = IMM_W
) (
    input  logic [W-1:0]  idx,
    input  logic [W-1:0]  mod,
    input  logic          use_imm,
    input  logic [IW-1:0] imm,
    input  logic [W-1:0]  base,
    input  logic [W-1:0]  len,
    output logic [W-1:0]  mod_eff,
    output logic [W-1:0]  next
);
    logic signed [W+1:0] sum, lim, lo, span, res;

    always_comb begin
        mod_eff = use_imm ? {{(W-IW){imm[IW-1]}}, imm} : mod;
        sum  = $signed({2'b00, idx}) + $signed({{2{mod_eff[W-1]}}, mod_eff});
        lo   = $signed({2'b00, base});
        span = $signed({2'b00, len});
        lim  = lo + span;
        res  = sum;
        if (len != '0) begin
            if (sum >= lim)
                res = sum - span;
            else if (sum < lo)
                res = sum + span;
        end
        next = res[W-1:0];
    end
endmodule

// File: rtl/circ_dag.sv
module circ_dag
    import dag_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bank_sel,
    input  logic              wr_en,
    input  logic [2:0]        wr_kind,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [OFF_W-1:0]  wr_data,
    input  logic              req_valid,
    input  logic [SEL_W-1:0]  req_idx,
    input  logic [SEL_W-1:0]  req_mod,
    input  logic              req_imm_en,
    input  logic [IMM_W-1:0]  req_imm,
    input  logic              req_pre,
    input  logic              req_update,
    output logic [ADDR_W-1:0] addr,
    output logic              addr_valid
);
    dag_req_t            req;
    logic [OFF_W-1:0]    cur_idx, cur_mod, cur_len, cur_base, mod_eff, nxt;
    logic [PAGE_W-1:0]   cur_page;
    logic [ADDR_W-1:0]   addr_q;
    logic                valid_q;

    assign req = '{idx: req_idx, mod: req_mod, imm_en: req_imm_en,
                   imm: req_imm, pre: req_pre, update: req_update};

    dag_regfile #(.W(OFF_W), .PW(PAGE_W), .NP(N_PTR), .NB(N_BANK)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .bank    (bank_sel),
        .wr_en   (wr_en),
        .wr_kind (wr_kind),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .upd_en  (req_valid && req.update),
        .upd_sel (req.idx),
        .upd_val (nxt),
        .rd_isel (req.idx),
        .rd_msel (req.mod),
        .rd_idx  (cur_idx),
        .rd_mod  (cur_mod),
        .rd_len  (cur_len),
        .rd_base (cur_base),
        .rd_page (cur_page)
    );

    dag_alu #(.W(OFF_W), .IW(IMM_W)) u_alu (
        .idx     (cur_idx),
        .mod     (cur_mod),
        .use_imm (req.imm_en),
        .imm     (req.imm),
        .base    (cur_base),
        .len     (cur_len),
        .mod_eff (mod_eff),
        .next    (nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q  <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= req_valid;
            if (req_valid)
                addr_q <= {cur_page, (req.pre ? nxt : cur_idx)};
        end
    end

    assign addr       = addr_q;
    assign addr_valid = valid_q;

    // R11: strobe follows the request by one cycle
    p_valid_rise_r11: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> addr_valid);
    p_valid_idle_r11: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !addr_valid);
    // R6: page field comes from the selected copy
    p_page_field_r6: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> addr[ADDR_W-1:OFF_W] == $past(cur_page));

    logic [OFF_W:0] win_end;
    logic [OFF_W-1:0] mag;
    assign win_end = {1'b0, cur_base} + {1'b0, cur_len};
    assign mag     = mod_eff[OFF_W-1] ? (~mod_eff + 1'b1) : mod_eff;
    // R8: a pointer inside its window stays inside after modification
    p_in_window_r8: assert property (@(posedge clk) disable iff (rst)
        req_valid && cur_len != '0 && cur_idx >= cur_base &&
        {1'b0, cur_idx} < win_end && mag < cur_len
        |-> nxt >= cur_base && {1'b0, nxt} < win_end);
endmodule

// File: tb/circ_dag_test.sv
module circ_dag_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        bank_sel, wr_en, req_valid, req_imm_en, req_pre, req_update;
    logic [2:0]  wr_kind;
    logic [1:0]  wr_sel, req_idx, req_mod;
    logic [15:0] wr_data;
    logic [7:0]  req_imm;
    logic [23:0] addr;
    logic        addr_valid;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    int m_idx[2][4], m_mod[2][4], m_len[2][4], m_base[2][4], m_page[2];

    always #5 clk = ~clk;

    circ_dag uut (.*);

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int step_val(int idx, int modv, int base, int len);
        int s = idx + modv;
        if (len != 0) begin
            if (s > base + len - 1) s = s - len;
            else if (s < base) s = s + len;
        end
        return s & 16'hFFFF;
    endfunction

    function automatic int sx16(int v);
        return (v & 16'h8000) ? (v | 32'hFFFF0000) : (v & 16'hFFFF);
    endfunction

    function automatic int sx8(int v);
        return (v & 8'h80) ? (v | 32'hFFFFFF00) : (v & 8'hFF);
    endfunction

    task automatic cyc(input string tag, input int bk,
                       input bit we, input int wk, input int ws, input int wd,
                       input bit rv, input int ri, input int rm,
                       input bit ie, input int im, input bit pr, input bit up);
        int modv, nx, exp_addr;
        bank_sel = bk[0]; wr_en = we; wr_kind = wk[2:0]; wr_sel = ws[1:0];
        wr_data = wd[15:0]; req_valid = rv; req_idx = ri[1:0]; req_mod = rm[1:0];
        req_imm_en = ie; req_imm = im[7:0]; req_pre = pr; req_update = up;
        modv = ie ? sx8(im) : sx16(m_mod[bk][rm]);
        nx = step_val(m_idx[bk][ri], modv, m_base[bk][ri], m_len[bk][ri]);
        exp_addr = (m_page[bk] << 16) | (pr ? nx : m_idx[bk][ri]);
        if (we) begin
            case (wk)
                0: m_idx[bk][ws]  = wd & 16'hFFFF;
                1: m_mod[bk][ws]  = wd & 16'hFFFF;
                2: m_len[bk][ws]  = wd & 16'hFFFF;
                3: m_base[bk][ws] = wd & 16'hFFFF;
                4: m_page[bk]     = wd & 8'hFF;
                default: ;
            endcase
        end
        if (rv && up) m_idx[bk][ri] = nx;
        @(posedge clk);
        @(negedge clk);
        check({tag, " valid"}, int'(addr_valid), int'(rv));
        if (rv) check({tag, " addr"}, int'(addr), exp_addr);
    endtask

    task automatic wr(input int bk, input int wk, input int ws, input int wd);
        cyc("R10 write", bk, 1, wk, ws, wd, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic acc(input string tag, input int bk, input int ri, input int rm,
                       input bit ie, input int im, input bit pr, input bit up);
        cyc(tag, bk, 0, 0, 0, 0, 1, ri, rm, ie, im, pr, up);
    endtask

    initial begin
        #(10 * 200000);
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int seed;
        seed = 13;
        void'($urandom(seed));
        for (int b = 0; b < 2; b++) begin
            m_page[b] = 0;
            for (int i = 0; i < 4; i++) begin
                m_idx[b][i] = 0; m_mod[b][i] = 0; m_len[b][i] = 0; m_base[b][i] = 0;
            end
        end
        rst = 1; bank_sel = 0; wr_en = 0; wr_kind = 0; wr_sel = 0; wr_data = 0;
        req_valid = 0; req_idx = 0; req_mod = 0; req_imm_en = 0; req_imm = 0;
        req_pre = 0; req_update = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset valid", int'(addr_valid), 0);
        check("R1 reset addr", int'(addr), 0);
        rst = 0;
        acc("R1 reset regs", 0, 3, 2, 0, 0, 1, 0);
        check("R1 literal", int'(addr), 0);
        cyc("R11 idle", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);

        // page and post-modify
        wr(0, 4, 0, 16'h005A);
        wr(0, 0, 0, 16'h1234);
        wr(0, 1, 1, 3);
        acc("R6 page", 0, 0, 1, 0, 0, 0, 1);
        check("R6 literal", int'(addr), 24'h5A1234);
        acc("R2 post", 0, 0, 1, 0, 0, 0, 1);
        check("R2 literal", int'(addr), 24'h5A1237);
        // pre with update
        wr(0, 0, 1, 16'h0100);
        wr(0, 1, 2, 16'h0010);
        acc("R3 pre", 0, 1, 2, 0, 0, 1, 1);
        check("R3 literal", int'(addr), 24'h5A0110);
        acc("R3 kept", 0, 1, 2, 0, 0, 0, 0);
        check("R3 kept literal", int'(addr), 24'h5A0110);
        // pre without update
        acc("R4 pre noupd", 0, 1, 2, 0, 0, 1, 0);
        check("R4 literal", int'(addr), 24'h5A0120);
        acc("R4 unchanged", 0, 1, 2, 0, 0, 0, 0);
        check("R4 unchanged literal", int'(addr), 24'h5A0110);
        // immediate
        acc("R5 imm neg", 0, 1, 0, 1, 8'hFE, 0, 1);
        acc("R5 imm after", 0, 1, 0, 1, 8'h7F, 1, 1);
        check("R5 literal", int'(addr), 24'h5A018D);
        // linear wrap at 16-bit edge
        wr(0, 0, 2, 16'hFFFF);
        acc("R7 carry", 0, 2, 0, 1, 1, 1, 1);
        check("R7 literal", int'(addr), 24'h5A0000);
        acc("R7 borrow", 0, 2, 0, 1, 8'hFF, 1, 1);
        check("R7 borrow literal", int'(addr), 24'h5AFFFF);
        // circular wrap
        wr(0, 3, 3, 16'h0200);
        wr(0, 2, 3, 8);
        wr(0, 0, 3, 16'h0206);
        acc("R8 up", 0, 3, 1, 0, 0, 0, 1);
        acc("R8 after up", 0, 3, 1, 0, 0, 0, 0);
        check("R8 up literal", int'(addr), 24'h5A0201);
        acc("R8 down", 0, 3, 0, 1, 8'hFC, 1, 1);
        check("R8 down literal", int'(addr), 24'h5A0205);
        // secondary copy
        acc("R9 sec zero", 1, 0, 1, 0, 0, 0, 0);
        check("R9 sec literal", int'(addr), 0);
        wr(1, 4, 0, 16'h0033);
        wr(1, 0, 0, 16'h4444);
        acc("R9 sec page", 1, 0, 0, 0, 0, 0, 0);
        check("R9 sec page literal", int'(addr), 24'h334444);
        acc("R9 prim intact", 0, 0, 1, 0, 0, 0, 0);
        check("R9 prim literal", int'(addr), 24'h5A123A);
        // collision
        cyc("R10 collide", 0, 1, 0, 0, 16'h7777, 1, 0, 1, 0, 0, 0, 1);
        acc("R10 winner", 0, 0, 1, 0, 0, 0, 0);
        check("R10 literal", int'(addr), 24'h5A123D);
        cyc("R10 other", 0, 1, 0, 2, 16'h0ABC, 1, 0, 1, 0, 0, 0, 1);
        acc("R10 other read", 0, 2, 1, 0, 0, 0, 0);
        check("R10 other literal", int'(addr), 24'h5A0ABC);
        // ignored write codes
        for (int k = 5; k < 8; k++) wr(0, k, 0, 16'hABCD);
        acc("R12 ignored", 0, 0, 0, 0, 0, 1, 0);
        check("R12 literal", int'(addr), 24'h5A1240);

        // random phase: windows wide enough for any immediate
        for (int b = 0; b < 2; b++) begin
            wr(b, 4, 0, $urandom_range(255));
            for (int i = 0; i < 4; i++) begin
                int L, B;
                L = (i == 3) ? 0 : $urandom_range(400, 130);
                B = $urandom_range(60000);
                wr(b, 3, i, B);
                wr(b, 2, i, L);
                wr(b, 0, i, B + $urandom_range(129));
                wr(b, 1, i, $urandom_range(128) - 64);
            end
        end
        for (int n = 0; n < 400; n++) begin
            int bk, ri, rm, im, op;
            bit ie, pr, up;
            string tag;
            bk = $urandom_range(1); ri = $urandom_range(3); rm = $urandom_range(3);
            ie = $urandom_range(1); im = $urandom_range(255);
            pr = $urandom_range(1); up = $urandom_range(1);
            op = $urandom_range(9);
            tag = !pr ? "R2 rand" : (up ? "R3 rand" : "R4 rand");
            if (ie) tag = {tag, " R5"};
            if (op == 0)
                cyc("R11 rand idle", bk, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
            else if (op == 1)
                cyc("R10 rand mod", bk, 1, 1, rm, $urandom_range(128) - 64,
                    1, ri, rm, ie, im, pr, up);
            else
                acc(tag, bk, ri, rm, ie, im, pr, up);
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule